// File: doc/BRIEF.md
# Serial LED-Driver Write Port

This block is the device-side write port of a cascadable dot-matrix LED driver. A host drives four slow serial pins: an active-low chip enable, a register select, a serial clock and serial data. The block samples them with a fast system clock and detects serial-clock edges in that clock domain. It shifts the data into one of two shift registers. The dot shift register holds one bit per LED. The control shift register is 8 bits wide.

When a write window closes, the shifted contents are copied to a destination. For a dot write, the destination is the dot latch that feeds the LED drivers. For a control write, it is one of two 7-bit control words.

A data-out pin lets several drivers be chained. In serial mode it carries the tail of the active shift register. Drivers can also be put in a feed-through mode for control writes. In that mode one 8-bit control write reaches every chip in the chain at once.

Top module: `ledser_wport`

## Requirements
- R1: While `rst_n` is low, both control words read zero. Reset does not change the dot latch or the dot shift register, and the selection returns to the dot register.
- R2: All four serial inputs pass through a two-stage synchronizer. A serial-clock rising edge seen while `ce_n` is low shifts `sdin` into bit 0 of the selected shift register, and every older bit moves up one place. Serial-clock edges while `ce_n` is high shift nothing.
- R3: `rsel` is captured when `ce_n` falls: 0 selects the dot register and 1 selects the control register. Changes of `rsel` while `ce_n` stays low have no effect.
- R4: Once `ce_n` is high and `sclk` is low after a dot write window, `dot_q` takes the dot shift register contents. Until then `dot_q` keeps its old value. The first bit shifted of a full-length write ends at bit `DOT_W-1`, and a 1 lights the LED.
- R5: On the copy after a control write, bit 7 of the control shift register picks the destination (1 = `cw1_q`, 0 = `cw0_q`), which receives bits 6:0. The other word keeps its value. Control data is sent most significant bit first.
- R6: With `cw1_q[0]` = 0 (serial mode), `sdout` equals bit `DOT_W-1` of the dot shift register when the dot register is selected, and bit 7 of the control shift register when the control register is selected.
- R7: With `cw1_q[0]` = 1 and the control register selected, `sdout` follows the synchronized `sdin`. With the dot register selected, `sdout` still shows the dot tail.
- R8: `commit_p` is high for exactly one system clock for each copy, in the same cycle the destination shows its new value. There is at most one copy per write window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable (write window) |
| rsel | input | 1 | Register select, captured when ce_n falls |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Cascade data out |
| dot_q | output | DOT_W | Dot latch, one bit per LED |
| cw0_q | output | 7 | Control word 0 (brightness and sleep field) |
| cw1_q | output | 7 | Control word 1 (bit 0 feed-through, bit 1 prescale) |
| commit_p | output | 1 | One-cycle pulse per completed copy |

## Verification
Some properties are checked on every cycle:
- the dot latch and control words change only in a copy cycle;
- the captured selection changes only on a chip-enable fall;
- nothing shifts while chip enable is high;
- the copy pulse never lasts two cycles.

Other behaviour can only be shown by the bench scenarios:
- where the first shifted bit lands after a full write;
- which control word bit 7 steers to;
- whether a held-high serial clock delays the copy;
- the data-out source in serial and feed-through modes;
- that reset leaves the dot contents intact.

// File: rtl/ledser_pkg.sv
`timescale 1ns/1ps
package ledser_pkg;
  localparam int CSR_W = 8;
  localparam int CW_W  = CSR_W - 1;

  typedef enum logic {SEL_DOT = 1'b0, SEL_CTL = 1'b1} regsel_e;

  // bit 7 of the control shift register names the destination word
  function automatic logic targets_cw1(input logic [CSR_W-1:0] sr);
    return sr[CSR_W-1];
  endfunction

  // cascade output source
  function automatic logic dout_pick(input regsel_e sel, input logic feed,
                                     input logic din_s, input logic ctl_tail,
                                     input logic dot_tail);
    if (sel == SEL_CTL) return feed ? din_s : ctl_tail;
    return dot_tail;
  endfunction
endpackage

// File: rtl/ledser_sync.sv
`timescale 1ns/1ps
module ledser_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= RST_VAL;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ledser_edges.sv
`timescale 1ns/1ps
module ledser_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_s,
  input  logic sck_s,
  output logic ce_fall,
  output logic sck_rise,
  output logic commit_win
);
  logic ce_n_d, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_d <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      ce_n_d <= ce_n_s;
      sck_d  <= sck_s;
    end
  end

  assign ce_fall    = ce_n_d & ~ce_n_s;
  assign sck_rise   = ~sck_d & sck_s & ~ce_n_s;
  assign commit_win = ce_n_s & ~sck_s;
endmodule

// File: rtl/ledser_shreg.sv
`timescale 1ns/1ps
module ledser_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  // no reset: contents survive the block reset
  always_ff @(posedge clk) begin
    if (en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/ledser_wport.sv
`timescale 1ns/1ps
module ledser_wport
  import ledser_pkg::*;
#(
  parameter int DOT_W = 160,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             rsel,
  input  logic             sclk,
  input  logic             sdin,
  output logic             sdout,
  output logic [DOT_W-1:0] dot_q,
  output logic [CW_W-1:0]  cw0_q,
  output logic [CW_W-1:0]  cw1_q,
  output logic             commit_p
);
  localparam logic [3:0] PIN_IDLE = 4'b1000;

  logic [3:0] pins_s;
  logic ce_n_s, rs_s, sck_s, din_s;
  logic ce_fall, sck_rise, commit_win;

  ledser_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ce_n, rsel, sclk, sdin}), .q(pins_s)
  );
  assign {ce_n_s, rs_s, sck_s, din_s} = pins_s;

  ledser_edges u_edges (
    .clk(clk), .rst_n(rst_n), .ce_n_s(ce_n_s), .sck_s(sck_s),
    .ce_fall(ce_fall), .sck_rise(sck_rise), .commit_win(commit_win)
  );

  regsel_e sel_q;
  logic    armed_q;
  logic    commit_ev, dot_en, ctl_en;
  logic [DOT_W-1:0] dot_sr;
  logic [CSR_W-1:0] ctl_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= SEL_DOT;
      armed_q <= 1'b0;
    end else if (ce_fall) begin
      sel_q   <= regsel_e'(rs_s);
      armed_q <= 1'b1;
    end else if (commit_ev) begin
      armed_q <= 1'b0;
    end
  end

  assign commit_ev = commit_win & armed_q;
  assign dot_en    = sck_rise & (sel_q == SEL_DOT);
  assign ctl_en    = sck_rise & (sel_q == SEL_CTL);

  ledser_shreg #(.W(DOT_W)) u_dot_sr (.clk(clk), .en(dot_en), .din(din_s), .q(dot_sr));
  ledser_shreg #(.W(CSR_W)) u_ctl_sr (.clk(clk), .en(ctl_en), .din(din_s), .q(ctl_sr));

  always_ff @(posedge clk) begin
    if (commit_ev && sel_q == SEL_DOT) dot_q <= dot_sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw0_q    <= '0;
      cw1_q    <= '0;
      commit_p <= 1'b0;
    end else begin
      commit_p <= commit_ev;
      if (commit_ev && sel_q == SEL_CTL) begin
        if (targets_cw1(ctl_sr)) cw1_q <= ctl_sr[CW_W-1:0];
        else                     cw0_q <= ctl_sr[CW_W-1:0];
      end
    end
  end

  assign sdout = dout_pick(sel_q, cw1_q[0], din_s, ctl_sr[CSR_W-1], dot_sr[DOT_W-1]);

  // R2: shift registers hold while chip enable is high
  p_shift_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_s |=> ($stable(dot_sr) && $stable(ctl_sr)));
  // R3: selection changes only on a chip-enable fall
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(sel_q));
  // R4: the dot latch moves only in a copy cycle
  p_dot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(dot_q));
  // R5: control words move only on a control copy
  p_cw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_ev && sel_q == SEL_CTL) |=> ($stable(cw0_q) && $stable(cw1_q)));
  // R8: copy pulse lasts a single cycle
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_p |=> !commit_p);
endmodule

// File: tb/ledser_wport_test.sv
`timescale 1ns/1ps
module ledser_wport_test;
  localparam int DW = 160;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ce_n, rsel, sclk, sdin;
  logic sdout, commit_p;
  logic [DW-1:0] dot_q;
  logic [6:0] cw0_q, cw1_q;

  ledser_wport uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rsel(rsel), .sclk(sclk), .sdin(sdin),
    .sdout(sdout), .dot_q(dot_q), .cw0_q(cw0_q), .cw1_q(cw1_q), .commit_p(commit_p)
  );

  int n_chk = 0, n_fail = 0, n_pulse = 0, cyc = 0;
  bit done = 0;

  // behavioural reference: input history plus architectural state
  bit h_ce[4], h_rs[4], h_ck[4], h_di[4];
  logic [DW-1:0] m_dot, m_dsr;
  logic [7:0] m_csr;
  logic [6:0] m_cw0 = 7'd0, m_cw1 = 7'd0;
  bit m_rs, m_arm, m_pulse, dot_known, ctl_known;
  bit e_fall, e_rise, e_com;
  logic exp_sd;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    for (int i = 3; i > 0; i--) begin
      h_ce[i] = h_ce[i-1]; h_rs[i] = h_rs[i-1]; h_ck[i] = h_ck[i-1]; h_di[i] = h_di[i-1];
    end
    h_ce[0] = ce_n; h_rs[0] = rsel; h_ck[0] = sclk; h_di[0] = sdin;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        h_ce[i] = 1; h_rs[i] = 0; h_ck[i] = 0; h_di[i] = 0;
      end
      m_cw0 = 0; m_cw1 = 0; m_rs = 0; m_arm = 0; m_pulse = 0;
    end else begin
      e_fall = h_ce[3] && !h_ce[2];
      e_rise = !h_ce[2] && !h_ck[3] && h_ck[2];
      e_com  = h_ce[2] && !h_ck[2] && m_arm;
      if (e_rise) begin
        if (m_rs) m_csr = {m_csr[6:0], h_di[2]};
        else      m_dsr = {m_dsr[DW-2:0], h_di[2]};
      end
      if (e_com) begin
        if (m_rs) begin
          if (m_csr[7]) m_cw1 = m_csr[6:0]; else m_cw0 = m_csr[6:0];
          ctl_known = 1;
        end else begin
          m_dot = m_dsr; dot_known = 1;
        end
      end
      m_pulse = e_com;
      if (e_fall) begin m_rs = h_rs[2]; m_arm = 1; end
      else if (e_com) m_arm = 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      if (commit_p) n_pulse++;
      chk("R5 cw0 per-cycle", cw0_q, m_cw0);
      chk("R5 cw1 per-cycle", cw1_q, m_cw1);
      chk("R8 pulse per-cycle", commit_p, m_pulse);
      if (dot_known) chk("R4 dot latch per-cycle", dot_q, m_dot);
      if (m_rs && m_cw1[0]) begin
        exp_sd = h_di[1];
        chk("R7 feed-through per-cycle", sdout, exp_sd);
      end else if (m_rs ? ctl_known : dot_known) begin
        exp_sd = m_rs ? m_csr[7] : m_dsr[DW-1];
        chk("R6 serial tail per-cycle", sdout, exp_sd);
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // opens a window, shifts bits MSB first, raises ce_n with sclk still high
  task automatic send(input logic sel, input int n, input logic [DW-1:0] bits,
                      input bit flip_rs, input bit chk_feed);
    @(negedge clk); rsel = sel; waitn(2);
    ce_n = 0; waitn(4);
    if (flip_rs) rsel = ~sel;
    for (int i = n-1; i >= 0; i--) begin
      sdin = bits[i]; sclk = 0; waitn(4);
      if (chk_feed) chk("R7 sdout follows sdin", sdout, bits[i]);
      sclk = 1; waitn(4);
    end
    ce_n = 1; waitn(8);
  endtask

  task automatic close_win();
    sclk = 0; waitn(6);
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 0;
    waitn(3); #1 rst_n = 1;
    waitn(3);
  endtask

  function automatic logic [DW-1:0] pat_a();
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++) p[i] = (i % 2 == 1);
    return p;
  endfunction

  function automatic logic [DW-1:0] pat_b();
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++) p[i] = (i % 3 == 0);
    return p;
  endfunction

  initial begin
    logic [DW-1:0] pa, pb;
    int p0;
    pa = pat_a(); pb = pat_b();
    rst_n = 0; ce_n = 1; rsel = 0; sclk = 0; sdin = 0;
    waitn(4); #1 rst_n = 1; waitn(3);

    chk("R1 cw0 after reset", cw0_q, 7'd0);
    chk("R1 cw1 after reset", cw1_q, 7'd0);
    chk("R8 no pulse after reset", commit_p, 1'b0);

    p0 = n_pulse;
    send(0, DW, pa, 0, 0); close_win();
    chk("R4 dot latch gets pattern A", dot_q, pa);
    chk("R8 one pulse per write", n_pulse, p0 + 1);
    chk("R6 serial dot tail", sdout, pa[DW-1]);

    send(1, 8, 8'h4D, 0, 0); close_win();
    chk("R5 cw0 written", cw0_q, 7'h4D);
    chk("R5 cw1 untouched", cw1_q, 7'h00);

    send(1, 8, 8'h82, 0, 0);
    chk("R6 serial ctl tail", sdout, 1'b1);
    close_win();
    chk("R5 cw1 written", cw1_q, 7'h02);
    chk("R5 cw0 kept", cw0_q, 7'h4D);

    // clock edges with the window closed must not shift
    for (int k = 0; k < 3; k++) begin
      sdin = 0; sclk = 1; waitn(4); sclk = 0; waitn(4);
    end
    chk("R2 no shift with ce_n high", sdout, 1'b1);
    chk("R2 cw1 still held", cw1_q, 7'h02);

    p0 = n_pulse;
    send(0, DW, pb, 1, 0);
    chk("R4 latch held while sclk high", dot_q, pa);
    chk("R8 no copy while sclk high", n_pulse, p0);
    close_win();
    chk("R3 flipped rsel ignored, dot got B", dot_q, pb);
    chk("R3 control words unchanged", {cw1_q, cw0_q}, {7'h02, 7'h4D});

    send(1, 8, 8'h81, 0, 0); close_win();
    chk("R5 cw1 feed-through set", cw1_q, 7'h01);
    send(1, 8, 8'h0A, 0, 1); close_win();
    chk("R5 cw0 written in feed mode", cw0_q, 7'h0A);
    chk("R5 cw1 kept in feed mode", cw1_q, 7'h01);

    send(0, DW, pa, 0, 0);
    chk("R7 dot tail in feed mode", sdout, pa[DW-1]);
    close_win();
    chk("R4 dot latch back to A", dot_q, pa);

    do_reset();
    chk("R1 cw0 cleared", cw0_q, 7'd0);
    chk("R1 cw1 cleared", cw1_q, 7'd0);
    chk("R1 dot latch kept", dot_q, pa);
    chk("R1 dot shift kept, dot selected", sdout, pa[DW-1]);

    p0 = n_pulse;
    send(1, 8, 8'h7F, 0, 0); close_win();
    chk("R5 cw0 all ones", cw0_q, 7'h7F);
    chk("R8 single pulse after reset", n_pulse, p0 + 1);

    waitn(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule